// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Table

This block routes a set of input interrupt pins to interrupt request messages. Each pin owns one redirection entry that supplies the vector, the destination, the trigger mode and a mask bit. When an unmasked entry's pin fires, the block emits a message that carries that entry's vector, destination and trigger mode. It emits at most one message per clock cycle, so when several entries request at once they are served by a fixed priority.

Software reaches every register through two bus offsets. Offset 0x00 holds an 8-bit register index. Offset 0x10 is a data window onto the 32-bit register that the index selects. Behind the window sit a unit ID register, a read-only version register and the redirection table. Each 64-bit table entry is split over two consecutive indices. The bus interface is a single-cycle write strobe with a combinational read path, and reads have no side effects.

Top module: `irq_router`

## Requirements
- R1: After a synchronous reset, every entry reads as masked (low word 0x00010000), its high word reads 0, the index register and the ID register read 0, and `msg_valid` is low.
- R2: A write at bus offset 0x00 stores `bus_wdata[7:0]` as the register index. A read at offset 0x00 returns the index in bits [7:0], with zeros above it.
- R3: Index 0x00 through the window (offset 0x10) is the ID register. Only bits [31:24] are writable, and every other bit reads 0.
- R4: Index 0x01 is a read-only version register. Bits [23:16] hold the highest entry number (NUM_ENT-1), bits [7:0] hold 0x11, and writes have no effect.
- R5: Entry n's low word is at index 0x10+2n. It holds the vector in bits [7:0], the trigger mode in bit 15 (1 = level, 0 = edge) and the mask in bit 16 (1 = masked). Every other bit reads 0.
- R6: Entry n's high word is at index 0x11+2n and holds the destination in bits [31:24]. Every other bit reads 0.
- R7: A read at an undefined index (for example 0x02, or 0x10+2·NUM_ENT) or at any bus offset other than 0x00 and 0x10 returns 0. A write there changes no register.
- R8: An unmasked edge-mode entry emits exactly one message for each rising edge of its pin, however long the pin stays high. The message carries the entry's vector and destination with `msg_level` = 0.
- R9: An unmasked level-mode entry emits one message per cycle while its pin is high, with `msg_level` = 1. A pin held high for H cycles yields H messages.
- R10: A masked entry emits no message. A rising edge seen while the entry is masked is discarded, and masking an entry whose edge is still waiting cancels that edge, so a later unmask produces no message.
- R11: When several entries request in the same cycle, the lowest-numbered entry is served first. An edge request that is not served waits until it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W (5) | Byte offset: 0x00 index, 0x10 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset and index |
| irq_in | input | NUM_ENT (24) | Interrupt input pins, one per entry |
| msg_valid | output | 1 | A message is presented this cycle |
| msg_vector | output | 8 | Vector of the message |
| msg_dest | output | 8 | Destination of the message |
| msg_level | output | 1 | 1 if the message came from a level-mode entry |

## Verification
Several rules are checked by assertions on every cycle. The arbiter grants at most one entry and only one that is requesting. A message follows each cycle that has any request and never follows a cycle without one. No request comes from a masked entry. An edge entry's waiting flag cannot appear without a rising edge. The bench scenarios cover what needs a sequence of stimulus. These are the register field layouts and read-zero rules, exactly one message per edge, exactly H messages for a level pin held H cycles, the service order under simultaneous edges, and the cancelling of a waiting edge by a mask write.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 8;

    // window indices
    localparam logic [IDX_W-1:0] IDX_UNIT_ID = 8'h00;
    localparam logic [IDX_W-1:0] IDX_VERSION = 8'h01;
    localparam logic [IDX_W-1:0] IDX_TABLE   = 8'h10;

    localparam logic [7:0] VERSION_CODE = 8'h11;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level;
        logic [7:0] vector;
    } route_t;

    localparam route_t ROUTE_RESET = '{dest: 8'h00, mask: 1'b1, level: 1'b0, vector: 8'h00};

    typedef struct packed {
        logic       level;
        logic [7:0] dest;
        logic [7:0] vector;
    } msg_t;

    function automatic logic [DATA_W-1:0] route_low(route_t e);
        return {15'b0, e.mask, e.level, 7'b0, e.vector};
    endfunction

    function automatic logic [DATA_W-1:0] route_high(route_t e);
        return {e.dest, 24'b0};
    endfunction

    function automatic logic [IDX_W-1:0] low_index(int n);
        return IDX_W'(int'(IDX_TABLE) + 2 * n);
    endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_ENT = 24,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output route_t            tbl_o [NUM_ENT]
);

    localparam logic [ADDR_W-1:0] OFF_INDEX  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_WINDOW = ADDR_W'(16);
    localparam logic [7:0]        LAST_ENT   = 8'(NUM_ENT - 1);

    logic [IDX_W-1:0] idx_q;
    logic [7:0]       unit_id_q;
    logic             idx_wr;
    logic             win_wr;
    route_t           tbl [NUM_ENT];
    logic             unused_bits;

    assign idx_wr      = bus_wr && (bus_addr == OFF_INDEX);
    assign win_wr      = bus_wr && (bus_addr == OFF_WINDOW);
    assign unused_bits = ^{bus_wdata[14:8], bus_wdata[23:17]};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            unit_id_q <= '0;
        end else begin
            if (idx_wr)
                idx_q <= bus_wdata[IDX_W-1:0];
            if (win_wr && idx_q == IDX_UNIT_ID)
                unit_id_q <= bus_wdata[31:24];
        end
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        localparam logic [IDX_W-1:0] LO_IDX = low_index(e);
        localparam logic [IDX_W-1:0] HI_IDX = LO_IDX + 1'b1;
        route_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= ROUTE_RESET;
            end else if (win_wr && idx_q == LO_IDX) begin
                ent_q.vector <= bus_wdata[7:0];
                ent_q.level  <= bus_wdata[15];
                ent_q.mask   <= bus_wdata[16];
            end else if (win_wr && idx_q == HI_IDX) begin
                ent_q.dest <= bus_wdata[31:24];
            end
        end

        assign tbl[e] = ent_q;
    end

    assign tbl_o = tbl;

    logic [DATA_W-1:0] win_data;

    always_comb begin
        win_data = '0;
        if (idx_q == IDX_UNIT_ID)
            win_data = {unit_id_q, 24'b0};
        else if (idx_q == IDX_VERSION)
            win_data = {8'b0, LAST_ENT, 8'b0, VERSION_CODE};
        for (int e = 0; e < NUM_ENT; e++) begin
            if (idx_q == low_index(e))
                win_data = route_low(tbl[e]);
            else if (idx_q == low_index(e) + 1'b1)
                win_data = route_high(tbl[e]);
        end
    end

    always_comb begin
        if (bus_addr == OFF_INDEX)
            bus_rdata = {{(DATA_W-IDX_W){1'b0}}, idx_q};
        else if (bus_addr == OFF_WINDOW)
            bus_rdata = win_data;
        else
            bus_rdata = '0;
    end

    // R2
    index_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !idx_wr |=> $stable(idx_q));

endmodule

// File: rtl/irq_router_src.sv
module irq_router_src #(
    parameter int NUM_ENT = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ENT-1:0] irq_in,
    input  logic [NUM_ENT-1:0] mask,
    input  logic [NUM_ENT-1:0] level,
    input  logic [NUM_ENT-1:0] grant,
    output logic [NUM_ENT-1:0] req
);

    logic [NUM_ENT-1:0] irq_q;
    logic [NUM_ENT-1:0] rise;
    logic [NUM_ENT-1:0] pend_q;

    assign rise = irq_in & ~irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= '0;
            pend_q <= '0;
        end else begin
            irq_q  <= irq_in;
            pend_q <= ((pend_q & ~grant) | rise) & ~mask & ~level;
        end
    end

    assign req = (pend_q | (irq_q & level)) & ~mask;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_chk
        // R8
        edge_pend_chk: assert property (@(posedge clk) disable iff (rst)
            (!level[i] && !pend_q[i] && !rise[i]) |=> !pend_q[i]);
    end

endmodule

// File: rtl/irq_router_arb.sv
module irq_router_arb #(
    parameter int NUM_ENT = 24,
    parameter int ENT_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ENT-1:0] req,
    output logic [NUM_ENT-1:0] grant,
    output logic [ENT_W-1:0]   sel,
    output logic               any
);

    logic [NUM_ENT-1:0] lower_busy;

    // lower_busy[i]: some entry below i is requesting
    assign lower_busy[0] = 1'b0;
    for (genvar i = 1; i < NUM_ENT; i++) begin : g_chain
        assign lower_busy[i] = lower_busy[i-1] | req[i-1];
    end

    assign grant = req & ~lower_busy;
    assign any   = |req;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_ENT; i++)
            if (grant[i])
                sel = ENT_W'(i);
    end

    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R11
    grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_ENT = 24,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_ENT-1:0] irq_in,
    output logic               msg_valid,
    output logic [7:0]         msg_vector,
    output logic [7:0]         msg_dest,
    output logic               msg_level
);

    localparam int ENT_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    route_t             tbl [NUM_ENT];
    logic [NUM_ENT-1:0] mask_v;
    logic [NUM_ENT-1:0] level_v;
    logic [NUM_ENT-1:0] req_v;
    logic [NUM_ENT-1:0] grant_v;
    logic [ENT_W-1:0]   sel;
    logic               any;
    msg_t               msg_q;
    logic               valid_q;

    irq_router_regs #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .tbl_o    (tbl)
    );

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_flat
        assign mask_v[e]  = tbl[e].mask;
        assign level_v[e] = tbl[e].level;
    end

    irq_router_src #(.NUM_ENT(NUM_ENT)) u_src (
        .clk   (clk),
        .rst   (rst),
        .irq_in(irq_in),
        .mask  (mask_v),
        .level (level_v),
        .grant (grant_v),
        .req   (req_v)
    );

    irq_router_arb #(.NUM_ENT(NUM_ENT), .ENT_W(ENT_W)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (req_v),
        .grant(grant_v),
        .sel  (sel),
        .any  (any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
        end else begin
            valid_q <= any;
            if (any)
                msg_q <= '{level: tbl[sel].level, dest: tbl[sel].dest, vector: tbl[sel].vector};
        end
    end

    assign msg_valid  = valid_q;
    assign msg_vector = msg_q.vector;
    assign msg_dest   = msg_q.dest;
    assign msg_level  = msg_q.level;

    // R9
    msg_follow_chk: assert property (@(posedge clk) disable iff (rst)
        any |=> msg_valid);

    // R10
    msg_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !any |=> !msg_valid);

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $past((req_v & mask_v) == '0));

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_ENT    = 24;
    localparam int ADDR_W     = 5;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NUM_ENT-1:0] irq_in = '0;
    logic               msg_valid;
    logic [7:0]         msg_vector;
    logic [7:0]         msg_dest;
    logic               msg_level;

    int n_checks = 0;
    int n_fails  = 0;

    logic [16:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .msg_valid (msg_valid),
        .msg_vector(msg_vector),
        .msg_dest  (msg_dest),
        .msg_level (msg_level)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        @(negedge clk);
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
        wr(5'h00, {24'b0, idx});
        wr(5'h10, d);
    endtask

    task automatic win_rd(input logic [7:0] idx, input logic [31:0] exp, input string tag);
        wr(5'h00, {24'b0, idx});
        rd(5'h10, exp, tag);
    endtask

    // low word: vector [7:0], level bit 15, mask bit 16; high word: dest [31:24]
    task automatic cfg(input int e, input logic [7:0] vec, input logic lvl,
                       input logic msk, input logic [7:0] dst);
        win_wr(8'(16 + 2*e), {15'b0, msk, lvl, 7'b0, vec});
        win_wr(8'(17 + 2*e), {dst, 24'b0});
    endtask

    task automatic expect_msg(input logic lvl, input logic [7:0] dst,
                              input logic [7:0] vec, input string tag);
        exp_q.push_back({lvl, dst, vec});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && msg_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R10 unexpected message: actual vec 0x%02h dest 0x%02h lvl %0d expected none",
                         msg_vector, msg_dest, msg_level);
            end else begin
                logic [16:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {15'b0, msg_level, msg_dest, msg_vector}, {15'b0, e});
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;

        // R1 reset state
        check("R1 msg_valid after reset", {31'b0, msg_valid}, 32'h0);
        rd(5'h00, 32'h0, "R1 index after reset");
        rd(5'h10, 32'h0, "R1 ID after reset");
        win_rd(8'h10, 32'h0001_0000, "R1 entry 0 masked");
        win_rd(8'h11, 32'h0, "R1 entry 0 dest");
        win_rd(8'h3E, 32'h0001_0000, "R1 last entry masked");

        // R2 index register
        wr(5'h00, 32'hABCD_1234);
        rd(5'h00, 32'h0000_0034, "R2 index readback");

        // R3 ID register
        win_wr(8'h00, 32'hFFFF_FFFF);
        rd(5'h10, 32'hFF00_0000, "R3 ID writable bits");

        // R4 version register
        win_rd(8'h01, 32'h0017_0011, "R4 version");
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, 32'h0017_0011, "R4 version read-only");

        // R5 / R6 field layout
        win_wr(8'h1C, 32'hFFFF_FFFF);
        rd(5'h10, 32'h0001_80FF, "R5 low word fields");
        win_wr(8'h1D, 32'hFFFF_FFFF);
        rd(5'h10, 32'hFF00_0000, "R6 high word fields");
        win_wr(8'h1C, 32'h0001_0000);

        // R7 undefined indices and offsets
        win_rd(8'h02, 32'h0, "R7 undefined index 0x02");
        win_wr(8'h40, 32'hFFFF_FFFF);
        rd(5'h10, 32'h0, "R7 index past table");
        win_rd(8'h3E, 32'h0001_0000, "R7 last entry untouched");
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, 32'h0, "R7 undefined offset");
        win_rd(8'h00, 32'hFF00_0000, "R7 ID untouched by stray write");

        // R8 edge entry: one message per rising edge
        cfg(1, 8'h41, 1'b0, 1'b0, 8'h03);
        expect_msg(1'b0, 8'h03, 8'h41, "R8 edge message");
        irq_in[1] = 1'b1;
        idle(4);
        irq_in[1] = 1'b0;
        idle(4);
        expect_msg(1'b0, 8'h03, 8'h41, "R8 second edge message");
        irq_in[1] = 1'b1;
        idle(1);
        irq_in[1] = 1'b0;
        idle(5);

        // R9 level entry held high for 5 cycles
        cfg(6, 8'h66, 1'b1, 1'b0, 8'h07);
        for (int k = 0; k < 5; k++)
            expect_msg(1'b1, 8'h07, 8'h66, "R9 level message");
        irq_in[6] = 1'b1;
        idle(5);
        irq_in[6] = 1'b0;
        idle(5);

        // R11 simultaneous edges, lower entry first
        cfg(2, 8'h52, 1'b0, 1'b0, 8'h01);
        cfg(5, 8'h55, 1'b0, 1'b0, 8'h02);
        expect_msg(1'b0, 8'h01, 8'h52, "R11 entry 2 first");
        expect_msg(1'b0, 8'h02, 8'h55, "R11 entry 5 second");
        irq_in[2] = 1'b1;
        irq_in[5] = 1'b1;
        idle(2);
        irq_in[2] = 1'b0;
        irq_in[5] = 1'b0;
        idle(5);

        // R10 edge while masked is discarded
        cfg(3, 8'h33, 1'b0, 1'b1, 8'h04);
        irq_in[3] = 1'b1;
        idle(2);
        irq_in[3] = 1'b0;
        idle(2);
        cfg(3, 8'h33, 1'b0, 1'b0, 8'h04);
        idle(6);
        expect_msg(1'b0, 8'h04, 8'h33, "R10 edge after unmask");
        irq_in[3] = 1'b1;
        idle(1);
        irq_in[3] = 1'b0;
        idle(5);

        // R10 masking a waiting edge cancels it (level entry 0 holds priority)
        cfg(0, 8'h10, 1'b1, 1'b0, 8'h09);
        cfg(4, 8'h44, 1'b0, 1'b0, 8'h0A);
        for (int k = 0; k < 4; k++)
            expect_msg(1'b1, 8'h09, 8'h10, "R11 level entry 0 wins");
        irq_in[0] = 1'b1;
        irq_in[4] = 1'b1;
        idle(1);
        irq_in[4] = 1'b0;
        win_wr(8'h18, 32'h0001_0044);
        idle(1);
        irq_in[0] = 1'b0;
        idle(3);
        win_wr(8'h18, 32'h0000_0044);
        idle(8);

        // every expected message arrived (R8, R9)
        check("R8 no missing messages", exp_q.size(), 32'h0);
        finish_run();
    end

endmodule